// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves one byte at a time over a clock line, a data-out line and a data-in line. There are no start, stop or parity bits. The host writes a byte into the transmit register, and that write is the only thing that starts a frame. While the byte shifts out least significant bit first, a byte shifts in on the data-in line. A transfer that only needs to receive must therefore still write a dummy byte. Between frames the data-out line rests high (mark level).

The block can be the clock master. In that case it drives a clock that rests high, and each half period is either a fixed number of system clocks from an internal divider or one pulse of an external timer tick. As clock slave it takes the clock from an input pin. That pin passes through a two-stage synchronizer, and edges are detected after it. Status consists of transmit-empty, receive-full and overrun. Overrun is the only error the block detects. Two interrupt requests follow the status flags, each gated by its own enable.

The frame controller has four states. ST_IDLE goes to ST_WAIT_FALL on a transmit write. ST_WAIT_FALL goes to ST_WAIT_RISE on a falling clock event, which drives the next bit out. ST_WAIT_RISE samples data-in on a rising event and then goes back to ST_WAIT_FALL, or to ST_FINISH after the last bit. ST_FINISH updates the receive side and the flags and returns to ST_IDLE.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, tx_empty=1, rx_full=0, overrun=0, sdo=1, sck_out=1, rx_data=0, and both interrupt requests are 0.
- R2: When tx_wr is pulsed while tx_empty=1, a frame starts and tx_empty reads 0 on the next cycle. tx_empty returns to 1 only after the frame ends. Without a write, the clock does not toggle and the flags do not change.
- R3: sdo is 1 before the first falling clock edge of a frame and returns to 1 once the frame ends.
- R4: In master mode (clk_master=1, use_timer=0), sck_out rests high and gives exactly 8 falling and 8 rising edges per frame. Each half period lasts HALF_DIV system clocks. Bit 0 of tx_data appears on sdo first. Each bit changes after a falling edge and is stable across the following rising edge.
- R5: At the end of a frame with rx_en=1 and rx_full=0, rx_data holds the 8 bits sampled on the rising edges, with the first sample in bit 0, and rx_full goes to 1. A pulse on rx_rd clears rx_full.
- R6: If a frame ends while rx_full=1, overrun goes to 1 and rx_data keeps the older byte.
- R7: A pulse on err_clr clears overrun on the next cycle.
- R8: With clk_master=0, the frame is clocked by edges of sck_in, and sck_oe is 0. With clk_master=1, sck_oe is 1.
- R9: In master mode with use_timer=1, each pulse of timer_tick ends one half period of sck_out.
- R10: With tx_en=0, a frame still runs, but sdo stays at 1 for the whole frame.
- R11: With rx_en=0, a frame ends without changing rx_full or rx_data.
- R12: tx_irq is 1 exactly when tx_irq_en=1 and tx_empty=1. rx_irq is 1 exactly when rx_irq_en=1 and rx_full=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| tx_wr | input | 1 | Write strobe for the transmit register; starts a frame |
| tx_data | input | DATA_W | Byte to transmit |
| rx_rd | input | 1 | Read strobe; clears receive-full |
| rx_data | output | DATA_W | Last accepted received byte |
| err_clr | input | 1 | Clears the overrun flag |
| tx_en | input | 1 | Enables driving data on sdo |
| rx_en | input | 1 | Enables loading received bytes |
| clk_master | input | 1 | 1: drive the serial clock, 0: follow sck_in |
| use_timer | input | 1 | Master half-period source: 0 divider, 1 timer_tick |
| timer_tick | input | 1 | External half-period pulse |
| tx_irq_en | input | 1 | Transmit interrupt enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| sck_in | input | 1 | External serial clock in slave mode |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Output enable for sck_out |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| tx_empty | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive register full |
| overrun | output | 1 | Receive overrun flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions assume that rx_rd and err_clr pulses are not issued in the cycle in which a frame ends. They also assume that each phase of sck_in lasts at least three system clocks, so that the synchronizer sees every edge. The bench issues its read and clear strobes only while tx_empty=1, when no frame can end. It holds each slave clock phase for six system clocks. In master mode it changes sdi one system clock after each observed falling edge, well ahead of the next rising sample.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_FALL,
        ST_WAIT_RISE,
        ST_FINISH
    } ssp_state_t;
endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic use_timer,
    input  logic timer_tick,
    output logic sck,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CNT_W-1:0] cnt;
    logic             div_tick;
    logic             tick;

    assign div_tick = (cnt == CNT_W'(HALF_DIV - 1));
    assign tick     = run & (use_timer ? timer_tick : div_tick);
    assign fall_ev  = tick & sck;
    assign rise_ev  = tick & ~sck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b1;
        end else if (!run) begin
            cnt <= '0;
            sck <= 1'b1;
        end else begin
            cnt <= div_tick ? '0 : cnt + 1'b1;
            if (tick) sck <= ~sck;
        end
    end
endmodule

// File: rtl/ssp_edge_sync.sv
module ssp_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    output logic fall_ev,
    output logic rise_ev
);
    logic [2:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 3'b111;
        else        sync_q <= {sync_q[1:0], sck_in};
    end

    assign fall_ev = sync_q[2] & ~sync_q[1];
    assign rise_ev = ~sync_q[2] & sync_q[1];
endmodule

// File: rtl/ssp_frame_fsm.sv
module ssp_frame_fsm
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              err_clr,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              fall_ev,
    input  logic              rise_ev,
    input  logic              sdi,
    output logic              busy,
    output logic              sdo,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic [DATA_W-1:0] rx_data
);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    ssp_state_t        state, state_nx;
    logic [DATA_W-1:0] tx_sh, rx_sh;
    logic [BIT_W-1:0]  bit_cnt;
    logic              last_bit;

    assign last_bit = (bit_cnt == BIT_W'(DATA_W - 1));
    assign busy     = (state == ST_WAIT_FALL) || (state == ST_WAIT_RISE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (tx_wr)   state_nx = ST_WAIT_FALL;
            ST_WAIT_FALL: if (fall_ev) state_nx = ST_WAIT_RISE;
            ST_WAIT_RISE: if (rise_ev) state_nx = last_bit ? ST_FINISH : ST_WAIT_FALL;
            ST_FINISH:                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            bit_cnt  <= '0;
            sdo      <= 1'b1;
            tx_empty <= 1'b1;
            rx_full  <= 1'b0;
            overrun  <= 1'b0;
            rx_data  <= '0;
        end else begin
            if (rx_rd) rx_full <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    sdo <= 1'b1;
                    if (tx_wr) begin
                        tx_sh    <= tx_data;
                        tx_empty <= 1'b0;
                        bit_cnt  <= '0;
                    end
                end
                ST_WAIT_FALL: begin
                    if (fall_ev) begin
                        sdo   <= tx_en ? tx_sh[0] : 1'b1;
                        tx_sh <= tx_sh >> 1;
                    end
                end
                ST_WAIT_RISE: begin
                    if (rise_ev) begin
                        rx_sh   <= {sdi, rx_sh[DATA_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_FINISH: begin
                    sdo      <= 1'b1;
                    tx_empty <= 1'b1;
                    if (rx_en) begin
                        if (rx_full) begin
                            overrun <= 1'b1;
                        end else begin
                            rx_data <= rx_sh;
                        end
                        rx_full <= 1'b1;
                    end
                end
            endcase
            if (err_clr) overrun <= 1'b0;
        end
    end
endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
    parameter int DATA_W   = 8,
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    input  logic              err_clr,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              clk_master,
    input  logic              use_timer,
    input  logic              timer_tick,
    input  logic              tx_irq_en,
    input  logic              rx_irq_en,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic busy;
    logic m_fall, m_rise, s_fall, s_rise;
    logic fall_ev, rise_ev;

    ssp_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy & clk_master),
        .use_timer  (use_timer),
        .timer_tick (timer_tick),
        .sck        (sck_out),
        .fall_ev    (m_fall),
        .rise_ev    (m_rise)
    );

    ssp_edge_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_in  (sck_in),
        .fall_ev (s_fall),
        .rise_ev (s_rise)
    );

    assign fall_ev = clk_master ? m_fall : s_fall;
    assign rise_ev = clk_master ? m_rise : s_rise;
    assign sck_oe  = clk_master;

    ssp_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_wr    (tx_wr),
        .tx_data  (tx_data),
        .rx_rd    (rx_rd),
        .err_clr  (err_clr),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .fall_ev  (fall_ev),
        .rise_ev  (rise_ev),
        .sdi      (sdi),
        .busy     (busy),
        .sdo      (sdo),
        .tx_empty (tx_empty),
        .rx_full  (rx_full),
        .overrun  (overrun),
        .rx_data  (rx_data)
    );

    assign tx_irq = tx_irq_en & tx_empty;
    assign rx_irq = rx_irq_en & rx_full;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_wr,
    input logic              rx_rd,
    input logic              err_clr,
    input logic              clk_master,
    input logic              sck_out,
    input logic              sdo,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              overrun,
    input logic [DATA_W-1:0] rx_data
);
    AST_WR_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr && tx_empty |=> !tx_empty); // R2
    AST_SDO_MARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> sdo); // R3
    AST_SCK_RESTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        clk_master && tx_empty |-> sck_out); // R4
    AST_READ_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_rd && tx_empty |=> !rx_full); // R5
    AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(rx_data)); // R6
    AST_CLEAR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr |=> !overrun); // R7
endmodule

bind sync_serial_port ssp_checker #(.DATA_W(DATA_W)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_wr      (tx_wr),
    .rx_rd      (rx_rd),
    .err_clr    (err_clr),
    .clk_master (clk_master),
    .sck_out    (sck_out),
    .sdo        (sdo),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .overrun    (overrun),
    .rx_data    (rx_data)
);

// File: tb/tb_sync_serial_port.sv
`timescale 1ns/1ps
module tb_sync_serial_port;
    localparam int DATA_W   = 8;
    localparam int HALF_DIV = 4;
    localparam int TICK_GAP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_wr = 0, rx_rd = 0, err_clr = 0;
    logic [DATA_W-1:0] tx_data = '0;
    logic [DATA_W-1:0] rx_data;
    logic tx_en = 1, rx_en = 1, clk_master = 1, use_timer = 0, timer_tick = 0;
    logic tx_irq_en = 0, rx_irq_en = 0, sck_in = 1, sdi = 0;
    logic sck_out, sck_oe, sdo, tx_empty, rx_full, overrun, tx_irq, rx_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sync_serial_port #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_data(rx_data), .err_clr(err_clr),
        .tx_en(tx_en), .rx_en(rx_en), .clk_master(clk_master),
        .use_timer(use_timer), .timer_tick(timer_tick),
        .tx_irq_en(tx_irq_en), .rx_irq_en(rx_irq_en), .sck_in(sck_in),
        .sck_out(sck_out), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
        .tx_empty(tx_empty), .rx_full(rx_full), .overrun(overrun),
        .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int half_len(input bit timer);
        return timer ? TICK_GAP : HALF_DIV;
    endfunction

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    // Master frame: bench acts as the far end, driving sdi after each fall
    task automatic master_frame(input logic [7:0] txb, input logic [7:0] rxb,
                                input bit timer, output logic [7:0] seen);
        int falls = 0, rises = 0, last_k = -1, bad_gap = 0;
        logic prev = 1'b1;
        seen = '0;
        @(negedge clk); tx_data = txb; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        chk(!tx_empty, "R2 write clears tx_empty", tx_empty, 0);
        chk(sdo == 1'b1, "R3 sdo mark before first fall", sdo, 1);
        for (int k = 0; k < 4000 && !tx_empty; k++) begin
            if (prev && !sck_out) begin
                if (last_k >= 0 && (k - last_k) != half_len(timer)) bad_gap++;
                last_k = k;
                sdi = rxb[falls];
                falls++;
            end else if (!prev && sck_out) begin
                if ((k - last_k) != half_len(timer)) bad_gap++;
                last_k = k;
                seen[rises] = sdo;
                rises++;
            end
            prev = sck_out;
            timer_tick = timer && (k % TICK_GAP == 0);
            @(negedge clk);
        end
        timer_tick = 1'b0;
        chk(falls == 8 && rises == 8, timer ? "R9 timer edge count" : "R4 edge count",
            falls * 16 + rises, 8 * 16 + 8);
        chk(bad_gap == 0, timer ? "R9 half period from timer_tick" : "R4 half period HALF_DIV",
            bad_gap, 0);
        chk(tx_empty && sdo, "R3 sdo back to mark after frame", sdo, 1);
    endtask

    // Slave frame: bench drives sck_in, six clocks per phase
    task automatic slave_frame(input logic [7:0] txb, input logic [7:0] rxb,
                               output logic [7:0] seen);
        @(negedge clk); tx_data = txb; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        for (int i = 0; i < 8; i++) begin
            sck_in = 1'b0; sdi = rxb[i];
            repeat (6) @(negedge clk);
            seen[i] = sdo;
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 150000) begin
            @(posedge clk); wd++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected finish", wd);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] txb, rxb, seen, first_rx, keep;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(tx_empty == 1 && rx_full == 0 && overrun == 0, "R1 reset flags",
            {tx_empty, rx_full, overrun}, 3'b100);
        chk(sdo == 1 && sck_out == 1 && rx_data == 0 && !tx_irq && !rx_irq,
            "R1 reset outputs", {sdo, sck_out, rx_data}, {2'b11, 8'h00});
        // R2 no frame without a write
        repeat (40) begin
            @(negedge clk);
            if (sck_out !== 1'b1 || tx_empty !== 1'b1) chk(0, "R2 idle stays idle", sck_out, 1);
        end
        chk(tx_empty && sck_out, "R2 idle without write", {tx_empty, sck_out}, 2'b11);
        chk(sck_oe == 1'b1, "R8 sck_oe in master", sck_oe, 1);

        // R4/R5 random master frames with directed corners mixed in
        for (int n = 0; n < 6; n++) begin
            txb = (n == 0) ? 8'h00 : (n == 1) ? 8'hFF : 8'($urandom);
            rxb = (n == 0) ? 8'hFF : (n == 1) ? 8'h01 : 8'($urandom);
            master_frame(txb, rxb, 1'b0, seen);
            chk(seen == txb, "R4 LSB-first bits on sdo", seen, txb);
            chk(rx_full && rx_data == rxb, "R5 received byte", rx_data, rxb);
            pulse(rx_rd);
            chk(!rx_full, "R5 read clears rx_full", rx_full, 0);
        end

        // R12 interrupt requests
        tx_irq_en = 1; rx_irq_en = 1;
        @(negedge clk);
        chk(tx_irq && !rx_irq, "R12 tx_irq when empty", {tx_irq, rx_irq}, 2'b10);
        rxb = 8'($urandom);
        master_frame(8'($urandom), rxb, 1'b0, seen);
        chk(tx_irq && rx_irq, "R12 both irqs after frame", {tx_irq, rx_irq}, 2'b11);
        pulse(rx_rd);
        chk(!rx_irq, "R12 rx_irq drops on read", rx_irq, 0);
        tx_irq_en = 0; rx_irq_en = 0;
        @(negedge clk);
        chk(!tx_irq, "R12 tx_irq gated by enable", tx_irq, 0);

        // R6 overrun, R7 clear
        first_rx = 8'hA5;
        master_frame(8'h3C, first_rx, 1'b0, seen);
        master_frame(8'hC3, 8'h5A, 1'b0, seen);
        chk(overrun, "R6 overrun set", overrun, 1);
        chk(rx_data == first_rx, "R6 older byte kept", rx_data, first_rx);
        pulse(err_clr);
        chk(!overrun, "R7 err_clr clears overrun", overrun, 0);
        pulse(rx_rd);

        // R9 timer-tick source
        use_timer = 1;
        txb = 8'($urandom); rxb = 8'($urandom);
        master_frame(txb, rxb, 1'b1, seen);
        chk(seen == txb && rx_data == rxb, "R9 timer frame data", {seen, rx_data}, {txb, rxb});
        pulse(rx_rd);
        use_timer = 0;

        // R10 transmit disabled: sdo stays at mark
        tx_en = 0;
        master_frame(8'h00, 8'h66, 1'b0, seen);
        chk(seen == 8'hFF, "R10 sdo held high with tx_en=0", seen, 8'hFF);
        chk(rx_data == 8'h66, "R10 receive-only via dummy write", rx_data, 8'h66);
        pulse(rx_rd);
        tx_en = 1;

        // R11 receive disabled
        keep = rx_data;
        rx_en = 0;
        master_frame(8'($urandom), 8'h99, 1'b0, seen);
        chk(!rx_full && rx_data == keep, "R11 rx_en=0 leaves receive side", rx_data, keep);
        rx_en = 1;

        // R8 slave mode
        clk_master = 0;
        @(negedge clk);
        chk(sck_oe == 1'b0, "R8 sck_oe low in slave", sck_oe, 0);
        for (int n = 0; n < 3; n++) begin
            txb = 8'($urandom); rxb = 8'($urandom);
            slave_frame(txb, rxb, seen);
            chk(tx_empty, "R8 slave frame completes", tx_empty, 1);
            chk(seen == txb, "R8 slave sdo bits", seen, txb);
            chk(rx_full && rx_data == rxb, "R8 slave received byte", rx_data, rxb);
            pulse(rx_rd);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule